// File: doc/BRIEF.md
# Six-Channel Programmable Delay Generator

The block produces six delayed timing outputs from a single trigger strobe. Every channel holds its own delay, pulse width, output mode and polarity. When a trigger is accepted, one shared time base starts counting clock ticks from zero. Each channel compares that count against its 44-bit delay. When its delay is reached, the channel raises a one-cycle done strobe, and that strobe can serve as an interrupt source.

In pulse mode, a channel's output goes active for a programmed number of cycles. In gate mode, two neighbouring channels (0 with 1, 2 with 3, 4 with 5) drive one gate on the even channel's output. The gate's leading edge comes from the even channel's delay and its trailing edge from the odd channel's delay.

The live configuration is copied into shadow registers while the block is idle. The shadows are frozen for the whole run, so writes made during a run take effect only on the next run. Coarse clock-domain timing is all this block provides; finer interpolation and output drivers sit elsewhere.

Top module: `dly_gen_top`

## Requirements
- R1: A trigger sampled at rising edge k starts a run. Channel i with delay d produces a done_o[i] strobe that is high for exactly one cycle, after edge k+2+d, and only once per run.
- R2: In pulse mode (mode bit 0), out_o[i] is active after edges k+2+d through k+1+d+w, where w is the programmed width. A width of 0 behaves as a width of 1.
- R3: A delay of 0 is the minimum delay: the output and done strobe of that channel change at edge k+2.
- R4: If channel 2p has mode bit 1, pair p is in gate mode. out_o[2p] is active after edges k+2+de through k+1+dl, where de is the delay of channel 2p and dl is the delay of channel 2p+1. out_o[2p+1] stays at its idle level. Both channels still give their done strobes.
- R5: In gate mode with dl not greater than de, out_o[2p] stays at its idle level. gate_err_o[p] becomes 1 after edge k+1 and holds until the next accepted trigger.
- R6: With the polarity bit at 1, a channel idles high and is active low. With the polarity bit at 0, it idles low and is active high.
- R7: A trigger that arrives while busy_o is 1 does not restart the run. It sets overrun_o, which stays set until reset.
- R8: Configuration writes made while busy_o is 1 do not change the current run.
- R9: After reset, all outputs, done strobes, busy_o, overrun_o and gate_err_o are 0. All stored delays, widths, mode bits and polarity bits are 0.
- R10: busy_o is 1 from the edge that accepts a trigger until every channel has fired and every pulse has ended.
- R11: Delays are compared over all 44 bits. A delay with bit 40 set does not fire at the count given by its low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger strobe; each high cycle is one trigger |
| cfg_we_i | input | 1 | Write the fields below into the selected channel |
| cfg_sel_i | input | 3 | Channel index 0..5 |
| cfg_delay_i | input | 44 | Delay in clock ticks |
| cfg_width_i | input | 32 | Pulse width in clock ticks |
| cfg_mode_i | input | 1 | 0 pulse, 1 gate (used on even channels for the pair) |
| cfg_inv_i | input | 1 | 1 inverts the output polarity |
| out_o | output | 6 | Channel outputs |
| done_o | output | 6 | One-cycle completion strobes |
| busy_o | output | 1 | A run is in progress |
| overrun_o | output | 1 | Sticky flag: trigger seen while busy |
| gate_err_o | output | 3 | Per pair: gate delays out of order in the last run |

## Verification
On every cycle, the assertions check several properties. The time base advances by exactly one per cycle during a run. Each channel fires at most once per run. Shadow settings stay frozen while busy. A trigger during a run sets the overrun flag, and the flag never drops without reset. A gate with misordered delays never opens, and the odd output of a gated pair holds its idle level. The exact edge on which each output rises and falls, the pulse widths, polarity, the gate window, the ignored mid-run write and trigger, and the full-width delay compare are shown only by the bench's scenarios. The bench compares cycle-accurate traces against values it computes from the programmed settings.

// File: rtl/dly_pkg.sv
`timescale 1ns/1ps
package dly_pkg;
  localparam int unsigned NCH_DEF   = 6;
  localparam int unsigned DLY_W_DEF = 44;
  localparam int unsigned WID_W_DEF = 32;

  typedef enum logic {
    MODE_PULSE = 1'b0,
    MODE_GATE  = 1'b1
  } chan_mode_e;
endpackage

// File: rtl/dly_cfg.sv
`timescale 1ns/1ps
module dly_cfg #(
  parameter int unsigned NCH = 6,
  parameter int unsigned DW  = 44,
  parameter int unsigned WW  = 32,
  localparam int unsigned SW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    we,
  input  logic [SW-1:0]           sel,
  input  logic [DW-1:0]           delay,
  input  logic [WW-1:0]           width,
  input  logic                    mode,
  input  logic                    inv,
  output logic [NCH-1:0][DW-1:0]  sh_delay,
  output logic [NCH-1:0][WW-1:0]  sh_width,
  output logic [NCH-1:0]          sh_mode,
  output logic [NCH-1:0]          sh_inv
);
  logic [NCH-1:0][DW-1:0] lv_delay;
  logic [NCH-1:0][WW-1:0] lv_width;
  logic [NCH-1:0]         lv_mode;
  logic [NCH-1:0]         lv_inv;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // live settings, written from the configuration port
    always_ff @(posedge clk) begin
      if (rst) begin
        lv_delay[i] <= '0;
        lv_width[i] <= '0;
        lv_mode[i]  <= 1'b0;
        lv_inv[i]   <= 1'b0;
      end else if (we && sel == SW'(i)) begin
        lv_delay[i] <= delay;
        lv_width[i] <= width;
        lv_mode[i]  <= mode;
        lv_inv[i]   <= inv;
      end
    end

    // shadows follow the live copy while idle and freeze during a run
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_delay[i] <= '0;
        sh_width[i] <= '0;
        sh_mode[i]  <= 1'b0;
        sh_inv[i]   <= 1'b0;
      end else if (!run) begin
        sh_delay[i] <= lv_delay[i];
        sh_width[i] <= lv_width[i];
        sh_mode[i]  <= lv_mode[i];
        sh_inv[i]   <= lv_inv[i];
      end
    end
  end

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ($stable(sh_delay) && $stable(sh_width) &&
                             $stable(sh_mode) && $stable(sh_inv))); // R8
endmodule

// File: rtl/dly_chan.sv
`timescale 1ns/1ps
module dly_chan #(
  parameter int unsigned DW = 44,
  parameter int unsigned WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] dly,
  input  logic [WW-1:0] wid,
  input  logic          gate_md,
  output logic          hit,
  output logic          fired,
  output logic          pls,
  output logic          done_q
);
  logic [WW-1:0] wcnt;

  assign hit = run && !fired && (cnt == dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      fired  <= 1'b0;
      pls    <= 1'b0;
      wcnt   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= hit;
      if (start) begin
        fired <= 1'b0;
        pls   <= 1'b0;
        wcnt  <= '0;
      end else if (hit) begin
        fired <= 1'b1;
        if (!gate_md) begin
          pls  <= 1'b1;
          wcnt <= (wid == '0) ? '0 : wid - 1'b1;
        end
      end else if (pls) begin
        if (wcnt == '0) pls  <= 1'b0;
        else            wcnt <= wcnt - 1'b1;
      end
    end
  end

  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit); // R1
endmodule

// File: rtl/dly_pair.sv
`timescale 1ns/1ps
module dly_pair #(
  parameter int unsigned DW = 44
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          arm,
  input  logic          gm,
  input  logic [DW-1:0] dly_e,
  input  logic [DW-1:0] dly_l,
  input  logic          hit_e,
  input  logic          hit_l,
  input  logic          pls_e,
  input  logic          pls_l,
  input  logic          done_e,
  input  logic          done_l,
  input  logic          inv_e,
  input  logic          inv_l,
  output logic [1:0]    out_q,
  output logic [1:0]    done_q,
  output logic          err_q
);
  import dly_pkg::*;

  logic gate_on;
  logic bad;
  logic g_q;
  logic lvl_e, lvl_l;

  assign gate_on = (gm == MODE_GATE);
  assign bad     = gate_on && (dly_l <= dly_e);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      g_q <= 1'b0;
    end else if (gate_on && !bad) begin
      if (hit_e)      g_q <= 1'b1;
      else if (hit_l) g_q <= 1'b0;
    end
  end

  assign lvl_e = gate_on ? g_q : pls_e;
  assign lvl_l = gate_on ? 1'b0 : pls_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      done_q <= '0;
      err_q  <= 1'b0;
    end else begin
      out_q  <= {lvl_l ^ inv_l, lvl_e ^ inv_e};
      done_q <= {done_l, done_e};
      if (arm) err_q <= bad;
    end
  end

  AST_GATE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    bad |-> !g_q); // R5
  AST_ODD_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(gm) |-> (out_q[1] == $past(inv_l))); // R4
endmodule

// File: rtl/dly_gen_top.sv
`timescale 1ns/1ps
module dly_gen_top
  import dly_pkg::*;
#(
  parameter int unsigned NCH = NCH_DEF,
  parameter int unsigned DW  = DLY_W_DEF,
  parameter int unsigned WW  = WID_W_DEF,
  localparam int unsigned SW = $clog2(NCH),
  localparam int unsigned NP = NCH / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_i,
  input  logic            cfg_we_i,
  input  logic [SW-1:0]   cfg_sel_i,
  input  logic [DW-1:0]   cfg_delay_i,
  input  logic [WW-1:0]   cfg_width_i,
  input  logic            cfg_mode_i,
  input  logic            cfg_inv_i,
  output logic [NCH-1:0]  out_o,
  output logic [NCH-1:0]  done_o,
  output logic            busy_o,
  output logic            overrun_o,
  output logic [NP-1:0]   gate_err_o
);
  logic                   run, start, start_d;
  logic [DW-1:0]          cnt;
  logic [NCH-1:0][DW-1:0] sh_delay;
  logic [NCH-1:0][WW-1:0] sh_width;
  logic [NCH-1:0]         sh_mode, sh_inv;
  logic [NCH-1:0]         hit, fired, pls, ch_done;

  assign start = trig_i && !run;

  // shared time base
  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      cnt       <= '0;
      start_d   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      start_d <= start;
      if (trig_i && run) overrun_o <= 1'b1;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        cnt <= cnt + 1'b1;
        if (&fired && !(|pls)) run <= 1'b0;
      end
    end
  end

  assign busy_o = run;

  dly_cfg #(.NCH(NCH), .DW(DW), .WW(WW)) u_cfg (
    .clk(clk), .rst(rst), .run(run),
    .we(cfg_we_i), .sel(cfg_sel_i), .delay(cfg_delay_i),
    .width(cfg_width_i), .mode(cfg_mode_i), .inv(cfg_inv_i),
    .sh_delay(sh_delay), .sh_width(sh_width),
    .sh_mode(sh_mode), .sh_inv(sh_inv)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pair
    for (genvar h = 0; h < 2; h++) begin : g_ch
      dly_chan #(.DW(DW), .WW(WW)) u_ch (
        .clk(clk), .rst(rst), .start(start), .run(run), .cnt(cnt),
        .dly(sh_delay[2*p+h]), .wid(sh_width[2*p+h]),
        .gate_md(sh_mode[2*p] == MODE_GATE),
        .hit(hit[2*p+h]), .fired(fired[2*p+h]),
        .pls(pls[2*p+h]), .done_q(ch_done[2*p+h])
      );
    end

    dly_pair #(.DW(DW)) u_pair (
      .clk(clk), .rst(rst), .start(start), .arm(start_d),
      .gm(sh_mode[2*p]),
      .dly_e(sh_delay[2*p]), .dly_l(sh_delay[2*p+1]),
      .hit_e(hit[2*p]), .hit_l(hit[2*p+1]),
      .pls_e(pls[2*p]), .pls_l(pls[2*p+1]),
      .done_e(ch_done[2*p]), .done_l(ch_done[2*p+1]),
      .inv_e(sh_inv[2*p]), .inv_l(sh_inv[2*p+1]),
      .out_q(out_o[2*p+1:2*p]), .done_q(done_o[2*p+1:2*p]),
      .err_q(gate_err_o[p])
    );
  end

  AST_TIMEBASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (cnt == $past(cnt) + 1'b1)); // R1
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (trig_i && run) |=> overrun_o); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (trig_i && run) |=> (cnt == $past(cnt) + 1'b1 || !run)); // R7
endmodule

// File: tb/tb_dly_gen_top.sv
`timescale 1ns/1ps
module tb_dly_gen_top;
  localparam int NCH = 6;
  localparam int CAP = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [43:0] cfg_delay_i = '0;
  logic [31:0] cfg_width_i = '0;
  logic        cfg_mode_i = 1'b0;
  logic        cfg_inv_i = 1'b0;
  logic [5:0]  out_o, done_o;
  logic        busy_o, overrun_o;
  logic [2:0]  gate_err_o;

  int checks = 0;
  int fails  = 0;

  longint e_d   [NCH];
  longint e_w   [NCH];
  bit     e_g   [NCH];
  bit     e_inv [NCH];

  logic [5:0] tr_out  [CAP];
  logic [5:0] tr_done [CAP];
  logic       tr_busy [CAP];
  logic       tr_ovr  [CAP];
  logic [2:0] tr_err  [CAP];

  always #2 clk = ~clk;

  dly_gen_top dut (
    .clk(clk), .rst(rst), .trig_i(trig_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_delay_i(cfg_delay_i),
    .cfg_width_i(cfg_width_i), .cfg_mode_i(cfg_mode_i),
    .cfg_inv_i(cfg_inv_i), .out_o(out_o), .done_o(done_o),
    .busy_o(busy_o), .overrun_o(overrun_o), .gate_err_o(gate_err_o)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mirror_clear();
    for (int i = 0; i < NCH; i++) begin
      e_d[i] = 0; e_w[i] = 0; e_g[i] = 0; e_inv[i] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    mirror_clear();
    @(negedge clk);
  endtask

  task automatic cfg(int ch, longint d, longint w, bit g, bit inv);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 3'(ch); cfg_delay_i = 44'(d);
    cfg_width_i = 32'(w); cfg_mode_i = g; cfg_inv_i = inv;
    @(negedge clk);
    cfg_we_i = 1'b0;
    e_d[ch] = d; e_w[ch] = w; e_g[ch] = g; e_inv[ch] = inv;
  endtask

  // trigger at edge k, then trace n cycles; at cycle ev a second trigger
  // and a write of delay 2 to channel 0 are driven for one cycle
  task automatic capture(int n, int ev);
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      tr_out[c] = out_o; tr_done[c] = done_o; tr_busy[c] = busy_o;
      tr_ovr[c] = overrun_o; tr_err[c] = gate_err_o;
      if (c == ev) begin
        trig_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 3'd0;
        cfg_delay_i = 44'd2; cfg_width_i = 32'd2;
        cfg_mode_i = 1'b0; cfg_inv_i = 1'b0;
      end else begin
        trig_i = 1'b0; cfg_we_i = 1'b0;
      end
    end
  endtask

  function automatic bit pair_bad(int p);
    return e_g[2*p] && (e_d[2*p+1] <= e_d[2*p]);
  endfunction

  function automatic logic exp_out(int ch, int c);
    int p = ch / 2;
    bit act;
    longint w = (e_w[ch] == 0) ? 1 : e_w[ch];
    if (e_g[2*p]) begin
      if (ch % 2 == 0)
        act = !pair_bad(p) && (c >= 2 + e_d[ch]) && (c < 2 + e_d[ch+1]);
      else
        act = 1'b0;
    end else begin
      act = (c >= 2 + e_d[ch]) && (c < 2 + e_d[ch] + w);
    end
    return act ^ e_inv[ch];
  endfunction

  // one check for outputs and one for done strobes per channel
  task automatic check_chan(int ch, int n, string req);
    int bad_o = 0, bad_d = 0;
    logic a_o = 0, x_o = 0, a_d = 0, x_d = 0;
    for (int c = 1; c <= n; c++) begin
      logic eo, ed;
      eo = exp_out(ch, c);
      ed = (c == 2 + e_d[ch]);
      if (tr_out[c][ch] !== eo && bad_o == 0) begin
        bad_o = c; a_o = tr_out[c][ch]; x_o = eo;
      end
      if (tr_done[c][ch] !== ed && bad_d == 0) begin
        bad_d = c; a_d = tr_done[c][ch]; x_d = ed;
      end
    end
    check(bad_o == 0, req, $sformatf("out ch%0d cycle %0d", ch, bad_o), a_o, x_o);
    check(bad_d == 0, "R1", $sformatf("done ch%0d cycle %0d", ch, bad_d), a_d, x_d);
  endtask

  task automatic t_reset();
    check(out_o == 0 && done_o == 0, "R9", "outputs after reset", {out_o, done_o}, 0);
    check(!busy_o && !overrun_o && gate_err_o == 0, "R9", "flags after reset",
          {busy_o, overrun_o, gate_err_o}, 0);
  endtask

  task automatic t_pulse();  // R2 R3 R10
    longint d[NCH] = '{0, 3, 5, 7, 10, 12};
    longint w[NCH] = '{1, 2, 0, 4, 3, 5};
    for (int i = 0; i < NCH; i++) cfg(i, d[i], w[i], 0, 0);
    capture(30, 0);
    for (int i = 0; i < NCH; i++) check_chan(i, 30, (i == 0) ? "R3" : "R2");
    check(tr_busy[1] == 1'b1, "R10", "busy during run", tr_busy[1], 1);
    check(tr_busy[30] == 1'b0, "R10", "idle after run", tr_busy[30], 0);
  endtask

  task automatic t_polarity();  // R6
    cfg(1, 3, 2, 0, 1);
    cfg(3, 7, 4, 0, 1);
    capture(30, 0);
    for (int i = 0; i < NCH; i++) check_chan(i, 30, "R6");
  endtask

  task automatic t_gate();  // R4 R5
    cfg(0, 4, 0, 1, 1);
    cfg(1, 9, 0, 0, 0);
    cfg(2, 6, 0, 1, 0);
    cfg(3, 6, 0, 0, 0);
    cfg(4, 2, 3, 0, 0);
    cfg(5, 8, 1, 0, 0);
    capture(30, 0);
    for (int i = 0; i < NCH; i++) check_chan(i, 30, (i == 2 || i == 3) ? "R5" : "R4");
    check(tr_err[2] == 3'b010, "R5", "gate error flags", tr_err[2], 3'b010);
    check(tr_err[30] == 3'b010, "R5", "gate error held", tr_err[30], 3'b010);
  endtask

  task automatic t_overrun();  // R7 R8
    cfg(0, 20, 2, 0, 0);
    for (int i = 1; i < NCH; i++) cfg(i, i, 2, 0, 0);
    check(overrun_o == 1'b0, "R7", "no overrun before", overrun_o, 0);
    capture(30, 5);
    for (int i = 0; i < NCH; i++) check_chan(i, 30, "R8");
    check(tr_ovr[6] == 1'b1, "R7", "overrun set", tr_ovr[6], 1);
    check(tr_busy[10] == 1'b1, "R7", "run continues", tr_busy[10], 1);
    check(overrun_o == 1'b1, "R7", "overrun sticky", overrun_o, 1);
    e_d[0] = 2;
  endtask

  task automatic t_wide();  // R11
    cfg(0, (64'd1 << 40) | 64'd4, 1, 0, 0);
    capture(20, 0);
    begin
      int hits = 0;
      for (int c = 1; c <= 20; c++) if (tr_done[c][0] || tr_out[c][0]) hits++;
      check(hits == 0, "R11", "no early fire on wide delay", hits, 0);
    end
    check(tr_busy[20] == 1'b1, "R11", "still counting", tr_busy[20], 1);
    do_reset();
    check(!overrun_o && !busy_o, "R7", "overrun cleared by reset",
          {overrun_o, busy_o}, 0);
  endtask

  task automatic t_defaults();  // R3 R9
    capture(10, 0);
    for (int i = 0; i < NCH; i++) check_chan(i, 10, "R3");
  endtask

  initial begin
    mirror_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_polarity();
    t_gate();
    t_overrun();
    t_wide();
    t_defaults();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule